// File: doc/BRIEF.md
# Youngest-Producer Hazard Finder

The block serves the issue stage of an out-of-order core. The core keeps its in-flight instructions in a circular scoreboard. Before an instruction issues, each of its source registers must be checked against that scoreboard. The block looks at every slot in parallel and finds the most recent in-flight instruction that will write the requested register. The caller can then wait on that producer or forward from it.

The scoreboard's issue pointer names the next slot to be allocated, so the slot just below it holds the newest instruction. The age order therefore wraps around the end of the array. The block handles the wrap without walking the entries in order. It splits the match vector into slots below the pointer and slots at or above it, and takes the highest-index match in each part. The lower part's result wins when both parts have a match.

One instance serves one source operand; a core with more operands uses more instances. The lookup itself is combinational. This top registers the result, so the answer appears one clock after the query.

Top module: `youngest_producer_finder`

## Requirements
- R1: Slot i counts as a producer only when its valid bit is 1, its destination field equals the query register, and its floating-point bit equals the query's floating-point bit. Slot i's destination sits at bits [i*REG_W +: REG_W] of the packed destination input.
- R2: A query for integer register 0 (floating-point bit 0, register 0) never reports a hazard. A query for floating-point register 0 is looked up like any other register.
- R3: When all matching slots sit at or above the issue pointer, the reported index is the highest matching index.
- R4: When matching slots exist below the issue pointer, the reported index is the highest matching index below the pointer.
- R5: When matches exist both below and at or above the issue pointer, the match below the pointer is reported, even if a match at or above it has a larger index.
- R6: When nothing matches, the hazard flag is 0 and the index is 0.
- R7: The hazard flag and index reflect the inputs sampled at the previous rising clock edge. While the active-low reset is held, both outputs are 0.
- R8: With the issue pointer at 0, every slot belongs to the upper group, so the highest matching index overall is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset of the result register |
| slot_valid_i | input | DEPTH | Per-slot in-flight flag |
| slot_dest_i | input | DEPTH*REG_W | Packed per-slot destination register numbers |
| slot_fp_i | input | DEPTH | Per-slot floating-point destination flag |
| issue_ptr_i | input | log2(DEPTH) | Next slot to be allocated |
| query_reg_i | input | REG_W | Source register being looked up |
| query_fp_i | input | 1 | Query addresses the floating-point register file |
| hazard_o | output | 1 | A matching producer exists |
| hazard_idx_o | output | log2(DEPTH) | Slot index of the youngest matching producer |

## Verification
The selection rule matters most when the lower and upper groups both contain a match in the same cycle. The two candidates then compete, and the rule must prefer the numerically smaller index below the pointer. The bench provokes this with directed cases: matches on both sides of the pointer, a pointer at 0 and at DEPTH-1, and register 0 in either file. Random scoreboards are drawn from a narrow range of register numbers so that collisions across the pointer happen often. Every result is judged against a reference model that walks backward in age order from the pointer, which is a different formulation from the split search.

// File: rtl/yphf_pkg.sv
package yphf_pkg;

    // Which half of the split search supplied the reported producer.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_LOW  = 2'd1,
        SRC_HIGH = 2'd2
    } pick_src_e;

endpackage

// File: rtl/yphf_match.sv
module yphf_match #(
    parameter int DEPTH = 8,
    parameter int REG_W = 5
) (
    input  logic [DEPTH-1:0]       slot_valid_i,
    input  logic [DEPTH*REG_W-1:0] slot_dest_i,
    input  logic [DEPTH-1:0]       slot_fp_i,
    input  logic [REG_W-1:0]       query_reg_i,
    input  logic                   query_fp_i,
    output logic [DEPTH-1:0]       match_o
);

    logic query_live;

    // Integer register 0 is hard-wired and never has a producer.
    assign query_live = query_fp_i | (|query_reg_i);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign match_o[g] = query_live
                          & slot_valid_i[g]
                          & (slot_fp_i[g] == query_fp_i)
                          & (slot_dest_i[g*REG_W +: REG_W] == query_reg_i);
    end

endmodule

// File: rtl/yphf_last_pick.sv
module yphf_last_pick #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] vec_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    // The highest set bit wins; a later loop pass overrides an earlier one.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/youngest_producer_finder.sv
module youngest_producer_finder #(
    parameter int DEPTH = 8,
    parameter int REG_W = 5,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [DEPTH-1:0]       slot_valid_i,
    input  logic [DEPTH*REG_W-1:0] slot_dest_i,
    input  logic [DEPTH-1:0]       slot_fp_i,
    input  logic [IDX_W-1:0]       issue_ptr_i,
    input  logic [REG_W-1:0]       query_reg_i,
    input  logic                   query_fp_i,
    output logic                   hazard_o,
    output logic [IDX_W-1:0]       hazard_idx_o
);

    import yphf_pkg::*;

    localparam int NGRP = 2;
    localparam int GLO  = 0;
    localparam int GHI  = 1;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } result_t;

    logic [DEPTH-1:0]            match_vec;
    logic [DEPTH-1:0]            below_mask;
    logic [NGRP-1:0][DEPTH-1:0]  grp_vec;
    logic [NGRP-1:0]             grp_found;
    logic [NGRP-1:0][IDX_W-1:0]  grp_idx;
    pick_src_e                   src;
    result_t                     res_d, res_q;

    yphf_match #(
        .DEPTH (DEPTH),
        .REG_W (REG_W)
    ) u_match (
        .slot_valid_i (slot_valid_i),
        .slot_dest_i  (slot_dest_i),
        .slot_fp_i    (slot_fp_i),
        .query_reg_i  (query_reg_i),
        .query_fp_i   (query_fp_i),
        .match_o      (match_vec)
    );

    // Slots with an index under the pointer are the newest part of the ring.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            below_mask[i] = (IDX_W'(i) < issue_ptr_i);
        end
    end

    assign grp_vec[GLO] = match_vec & below_mask;
    assign grp_vec[GHI] = match_vec & ~below_mask;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        yphf_last_pick #(
            .DEPTH (DEPTH)
        ) u_pick (
            .vec_i   (grp_vec[g]),
            .found_o (grp_found[g]),
            .idx_o   (grp_idx[g])
        );
    end

    always_comb begin
        if (grp_found[GLO]) begin
            src = SRC_LOW;
        end else if (grp_found[GHI]) begin
            src = SRC_HIGH;
        end else begin
            src = SRC_NONE;
        end

        res_d = '0;
        case (src)
            SRC_LOW: begin
                res_d.found = 1'b1;
                res_d.idx   = grp_idx[GLO];
            end
            SRC_HIGH: begin
                res_d.found = 1'b1;
                res_d.idx   = grp_idx[GHI];
            end
            default: res_d = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign hazard_o     = res_q.found;
    assign hazard_idx_o = res_q.idx;

endmodule

// File: rtl/yphf_chk.sv
module yphf_chk #(
    parameter int DEPTH = 8,
    parameter int REG_W = 5,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic [DEPTH-1:0]       slot_valid_i,
    input logic [DEPTH*REG_W-1:0] slot_dest_i,
    input logic [DEPTH-1:0]       slot_fp_i,
    input logic [IDX_W-1:0]       issue_ptr_i,
    input logic [REG_W-1:0]       query_reg_i,
    input logic                   query_fp_i,
    input logic                   hazard_o,
    input logic [IDX_W-1:0]       hazard_idx_o
);

    logic [DEPTH-1:0] raw_match;
    logic [DEPTH-1:0] raw_match_q;
    logic [DEPTH-1:0] below_q;
    logic [IDX_W-1:0] ptr_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            raw_match[i] = slot_valid_i[i] && (slot_fp_i[i] == query_fp_i)
                        && (slot_dest_i[i*REG_W +: REG_W] == query_reg_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            raw_match_q <= '0;
            ptr_q       <= '0;
            below_q     <= '0;
        end else begin
            raw_match_q <= raw_match;
            ptr_q       <= issue_ptr_i;
            for (int i = 0; i < DEPTH; i++) begin
                below_q[i] <= (i < int'(issue_ptr_i));
            end
        end
    end

    // R2
    x0_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!query_fp_i && query_reg_i == '0) |=> !hazard_o);

    // R6
    idle_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hazard_o |-> hazard_idx_o == '0);

    // R6
    no_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raw_match == '0) |=> !hazard_o);

    // R1
    real_producer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hazard_o |-> raw_match_q[hazard_idx_o]);

    // R5
    low_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hazard_o && ((raw_match_q & below_q) != '0)) |-> hazard_idx_o < ptr_q);

endmodule

bind youngest_producer_finder yphf_chk #(
    .DEPTH (DEPTH),
    .REG_W (REG_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_valid_i (slot_valid_i),
    .slot_dest_i  (slot_dest_i),
    .slot_fp_i    (slot_fp_i),
    .issue_ptr_i  (issue_ptr_i),
    .query_reg_i  (query_reg_i),
    .query_fp_i   (query_fp_i),
    .hazard_o     (hazard_o),
    .hazard_idx_o (hazard_idx_o)
);

// File: tb/youngest_producer_finder_tb.sv
module youngest_producer_finder_tb;

    localparam int DEPTH = 8;
    localparam int REG_W = 5;
    localparam int IDX_W = $clog2(DEPTH);

    logic                   clk_i = 1'b0;
    logic                   rst_ni;
    logic [DEPTH-1:0]       slot_valid_i;
    logic [DEPTH*REG_W-1:0] slot_dest_i;
    logic [DEPTH-1:0]       slot_fp_i;
    logic [IDX_W-1:0]       issue_ptr_i;
    logic [REG_W-1:0]       query_reg_i;
    logic                   query_fp_i;
    logic                   hazard_o;
    logic [IDX_W-1:0]       hazard_idx_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk_i = ~clk_i;

    youngest_producer_finder #(
        .DEPTH (DEPTH),
        .REG_W (REG_W)
    ) u_dut (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .slot_valid_i (slot_valid_i),
        .slot_dest_i  (slot_dest_i),
        .slot_fp_i    (slot_fp_i),
        .issue_ptr_i  (issue_ptr_i),
        .query_reg_i  (query_reg_i),
        .query_fp_i   (query_fp_i),
        .hazard_o     (hazard_o),
        .hazard_idx_o (hazard_idx_o)
    );

    // Reference: walk backward in age from the newest slot (pointer - 1).
    function automatic logic [IDX_W:0] ref_lookup();
        logic [IDX_W-1:0] s;
        if (!query_fp_i && query_reg_i == '0) return '0;
        for (int k = 1; k <= DEPTH; k++) begin
            s = issue_ptr_i - IDX_W'(k);
            if (slot_valid_i[s] && slot_fp_i[s] == query_fp_i
                && slot_dest_i[s*REG_W +: REG_W] == query_reg_i)
                return {1'b1, s};
        end
        return '0;
    endfunction

    task automatic check(input string req, input logic [IDX_W:0] exp);
        checks++;
        if ({hazard_o, hazard_idx_o} !== exp) begin
            failures++;
            $display("FAIL %s: got hazard=%0b idx=%0d, expected hazard=%0b idx=%0d",
                     req, hazard_o, hazard_idx_o, exp[IDX_W], exp[IDX_W-1:0]);
        end
    endtask

    // Drive at the falling edge, compare one full cycle later (R7 latency).
    task automatic run(input string req, input logic [IDX_W:0] exp);
        logic [IDX_W:0] model;
        model = ref_lookup();
        @(negedge clk_i);
        check(req, exp);
        if (model !== exp) begin
            checks++;
            failures++;
            $display("FAIL %s: model=%0h expected=%0h", req, model, exp);
        end
    endtask

    task automatic clear();
        slot_valid_i = '0;
        slot_dest_i  = '0;
        slot_fp_i    = '0;
    endtask

    task automatic put(input int s, input int r, input bit fp);
        slot_valid_i[s] = 1'b1;
        slot_dest_i[s*REG_W +: REG_W] = REG_W'(r);
        slot_fp_i[s] = fp;
    endtask

    task automatic query(input int r, input bit fp, input int ptr);
        query_reg_i = REG_W'(r);
        query_fp_i  = fp;
        issue_ptr_i = IDX_W'(ptr);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_ni = 1'b0;
        clear();
        put(3, 7, 1'b0);
        query(7, 1'b0, 5);
        repeat (3) @(negedge clk_i);
        check("R7 reset", '0);
        rst_ni = 1'b1;

        // R1: valid, register and file must all agree
        clear(); put(2, 9, 1'b0); query(9, 1'b0, 0);
        run("R1 plain match", {1'b1, 3'd2});
        clear(); put(2, 9, 1'b1); query(9, 1'b0, 0);
        run("R1 file mismatch", '0);
        clear(); put(2, 9, 1'b0); slot_valid_i[2] = 1'b0; query(9, 1'b0, 0);
        run("R1 invalid slot", '0);

        // R2
        clear(); put(4, 0, 1'b0); query(0, 1'b0, 2);
        run("R2 int x0", '0);
        clear(); put(4, 0, 1'b1); query(0, 1'b1, 2);
        run("R2 fp reg 0", {1'b1, 3'd4});

        // R3
        clear(); put(4, 6, 1'b0); put(6, 6, 1'b0); query(6, 1'b0, 3);
        run("R3 upper group", {1'b1, 3'd6});

        // R4
        clear(); put(1, 6, 1'b0); put(3, 6, 1'b0); query(6, 1'b0, 5);
        run("R4 lower group", {1'b1, 3'd3});

        // R5
        clear(); put(1, 6, 1'b0); put(7, 6, 1'b0); query(6, 1'b0, 4);
        run("R5 both groups", {1'b1, 3'd1});
        clear(); put(0, 11, 1'b1); put(5, 11, 1'b1); put(6, 11, 1'b1); query(11, 1'b1, 6);
        run("R5 pointer on match", {1'b1, 3'd5});

        // R6
        clear(); put(3, 2, 1'b0); query(12, 1'b0, 3);
        run("R6 no match", '0);

        // R8
        clear(); put(2, 8, 1'b0); put(7, 8, 1'b0); query(8, 1'b0, 0);
        run("R8 pointer zero", {1'b1, 3'd7});
        clear(); put(0, 8, 1'b0); put(6, 8, 1'b0); query(8, 1'b0, 7);
        run("R4 pointer at top", {1'b1, 3'd6});

        // R7 reset clears a live result
        clear(); put(5, 3, 1'b0); query(3, 1'b0, 2);
        @(negedge clk_i);
        rst_ni = 1'b0;
        @(negedge clk_i);
        check("R7 reset clears", '0);
        rst_ni = 1'b1;

        // Random: narrow register range forces collisions across the pointer (R3 R4 R5)
        for (int n = 0; n < 400; n++) begin
            for (int s = 0; s < DEPTH; s++) begin
                slot_valid_i[s] = 1'($urandom_range(0, 1));
                slot_dest_i[s*REG_W +: REG_W] = REG_W'($urandom_range(0, 3));
                slot_fp_i[s] = ($urandom_range(0, 3) == 0);
            end
            query($urandom_range(0, 3), ($urandom_range(0, 3) == 0), $urandom_range(0, DEPTH-1));
            begin
                logic [IDX_W:0] e;
                e = ref_lookup();
                @(negedge clk_i);
                check("R5 random", e);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule